// File: doc/BRIEF.md
# Operand-Capturing Reservation Station

This block holds decoded operations in front of a single execution unit. Each operation arrives with two source fields. A source is either a finished value or the tag of the producer that will compute it. An operation with a missing source parks in a free slot, and instruction issue continues with the operations behind it.

Every slot watches the shared result bus. A slot copies a value into its pending source as soon as a broadcast carries the matching tag. When all sources of a slot are filled, the slot competes for the unit. The slot that was allocated earliest wins, and it is released on the same clock edge that hands it over. The only back-pressure toward issue is the full flag, which is raised when every slot is occupied.

The result tag of an operation is built from a station identifier and the slot index. The unit carries this tag to the result bus, so later operations can name this slot as their producer.

Top module: `rs_station`

## Requirements
- R1: After reset no slot is occupied: `issueValid` is 0 and `full` is 0.
- R2: A dispatch is taken on a rising edge where `dispValid` is 1 and `full` is 0. `full` is 1 exactly when all 4 slots are occupied. A dispatch offered while `full` is 1 is dropped and never reaches the unit.
- R3: A source marked ready at dispatch (`dispRdy[s]`=1) keeps the value `dispData[s*32 +: 32]`.
- R4: A pending source copies `cdbData` on an edge where `cdbValid` is 1 and `cdbTag` equals its producer tag. A broadcast with any other tag leaves it pending.
- R5: If a broadcast carries the tag of a source in the same cycle that source is dispatched, the value is captured at dispatch.
- R6: A slot is offered to the unit only when all its sources hold values. With no such slot, `issueValid` is 0.
- R7: A younger operation whose sources are complete goes to the unit while an older operation is still waiting for a source.
- R8: Among slots that are ready, the one allocated earliest is offered, whatever its index.
- R9: The offered slot is released on the edge where `issueValid` and `issueReady` are both 1. While `issueReady` is 0, `issueValid` stays 1.
- R10: A new operation takes the lowest-numbered free slot. `issueTag` is `{STATION_ID, slot index}`, with the index in the low 2 bits. The default `STATION_ID` is 1, which gives tags 4 to 7.
- R11: A chain of dependent operations can be dispatched together, each naming its predecessor's result tag. The operations reach the unit one by one as each result is broadcast.
- R12: `issueData` packs source 0 in bits 31:0 and source 1 in bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dispValid | input | 1 | A decoded operation is offered |
| dispOp | input | 4 | Operation code of the offered operation |
| dispRdy | input | 2 | Per source: value present |
| dispData | input | 64 | Source values, source 0 in the low word |
| dispTag | input | 8 | Producer tags of pending sources, source 0 in the low nibble |
| full | output | 1 | All slots occupied; dispatch refused |
| cdbValid | input | 1 | Result bus carries a result this cycle |
| cdbTag | input | 4 | Tag of the broadcast result |
| cdbData | input | 32 | Broadcast result value |
| issueValid | output | 1 | A ready slot is offered to the unit |
| issueReady | input | 1 | The unit accepts the offered slot |
| issueOp | output | 4 | Operation code of the offered slot |
| issueData | output | 64 | Source values of the offered slot |
| issueTag | output | 4 | Result tag of the offered slot |

## Verification
The assertions check occupancy on every cycle. The checker counts accepted dispatches against completed hand-overs, and it requires `full` to agree with that count. It also requires that nothing is offered from an empty station, that an offer persists while the unit stalls, and that every offered tag carries the station identifier. Only the bench scenarios can show the rest: which slot wins when ready slots differ in age and index, that a source is captured when a broadcast coincides with dispatch, that broadcasts with other tags are ignored, and that a dependent chain drains in order with the right operand values.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
  localparam int ENTRIES = 4;
  localparam int SRCS    = 2;
  localparam int DATA_W  = 32;
  localparam int TAG_W   = 4;
  localparam int OP_W    = 4;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int SID_W   = TAG_W - IDX_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [ENTRIES-1:0] allocMask;  // one-hot slot written by dispatch
    logic [ENTRIES-1:0] freeMask;   // one-hot slot handed to the unit
    logic [IDX_W-1:0]   selIdx;     // slot currently offered
  } rsStrobe_t;
endpackage

// File: rtl/rs_ctrl.sv
`timescale 1ns/1ps
module rs_ctrl
  import rs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               dispValid,
  input  logic               issueReady,
  input  logic [ENTRIES-1:0] entRdy,
  output logic               full,
  output logic               issueValid,
  output rsStrobe_t          strb
);
  logic [ENTRIES-1:0] occ;
  logic [ENTRIES-1:0] ageM [ENTRIES];  // ageM[i][j]: slot i allocated before slot j
  logic [ENTRIES-1:0] allocMask;
  logic [ENTRIES-1:0] readyVec;
  logic [ENTRIES-1:0] pick;
  logic [ENTRIES-1:0] freeMask;
  logic [IDX_W-1:0]   selIdx;

  assign full     = &occ;
  assign readyVec = occ & entRdy;

  // lowest free slot wins allocation
  always_comb begin
    allocMask = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        allocMask    = '0;
        allocMask[i] = 1'b1;
      end
    end
    if (!dispValid || full) allocMask = '0;
  end

  // oldest ready slot: no other ready slot is older
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      pick[i] = readyVec[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && readyVec[j] && ageM[j][i]) pick[i] = 1'b0;
      end
    end
  end

  always_comb begin
    selIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (pick[i]) selIdx = IDX_W'(i);
    end
  end

  assign issueValid = |pick;
  assign freeMask   = pick & {ENTRIES{issueReady}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ <= '0;
      for (int k = 0; k < ENTRIES; k++) ageM[k] <= '0;
    end else begin
      occ <= (occ & ~freeMask) | allocMask;
      for (int k = 0; k < ENTRIES; k++) begin
        if (allocMask[k]) begin
          for (int j = 0; j < ENTRIES; j++) begin
            ageM[j][k] <= occ[j] & ~freeMask[j];
            ageM[k][j] <= 1'b0;
          end
        end
      end
    end
  end

  assign strb.allocMask = allocMask;
  assign strb.freeMask  = freeMask;
  assign strb.selIdx    = selIdx;
endmodule

// File: rtl/rs_data.sv
`timescale 1ns/1ps
module rs_data
  import rs_pkg::*;
#(
  parameter int STATION_ID = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rsStrobe_t              strb,
  input  logic [OP_W-1:0]        dispOp,
  input  logic [SRCS-1:0]        dispRdy,
  input  logic [SRCS*DATA_W-1:0] dispData,
  input  logic [SRCS*TAG_W-1:0]  dispTag,
  input  logic                   cdbValid,
  input  logic [TAG_W-1:0]       cdbTag,
  input  logic [DATA_W-1:0]      cdbData,
  output logic [ENTRIES-1:0]     entRdy,
  output logic [OP_W-1:0]        issueOp,
  output logic [SRCS*DATA_W-1:0] issueData,
  output logic [TAG_W-1:0]       issueTag
);
  logic [OP_W-1:0]   opQ [ENTRIES];
  logic [SRCS-1:0]   vQ  [ENTRIES];
  logic [DATA_W-1:0] dQ  [ENTRIES][SRCS];
  logic [TAG_W-1:0]  tQ  [ENTRIES][SRCS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        opQ[e] <= '0;
        vQ[e]  <= '0;
        for (int s = 0; s < SRCS; s++) begin
          dQ[e][s] <= '0;
          tQ[e][s] <= '0;
        end
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strb.allocMask[e]) opQ[e] <= dispOp;
        for (int s = 0; s < SRCS; s++) begin
          if (strb.allocMask[e]) begin
            if (dispRdy[s]) begin
              vQ[e][s] <= 1'b1;
              dQ[e][s] <= dispData[s*DATA_W +: DATA_W];
            end else if (cdbValid && cdbTag == dispTag[s*TAG_W +: TAG_W]) begin
              vQ[e][s] <= 1'b1;             // bypass of a coincident broadcast
              dQ[e][s] <= cdbData;
            end else begin
              vQ[e][s] <= 1'b0;
              tQ[e][s] <= dispTag[s*TAG_W +: TAG_W];
            end
          end else if (!vQ[e][s] && cdbValid && cdbTag == tQ[e][s]) begin
            vQ[e][s] <= 1'b1;
            dQ[e][s] <= cdbData;
          end
        end
      end
    end
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) entRdy[e] = &vQ[e];
  end

  assign issueOp = opQ[strb.selIdx];

  always_comb begin
    for (int s = 0; s < SRCS; s++) issueData[s*DATA_W +: DATA_W] = dQ[strb.selIdx][s];
  end

  assign issueTag = {SID_W'(STATION_ID), strb.selIdx};
endmodule

// File: rtl/rs_station.sv
`timescale 1ns/1ps
module rs_station
  import rs_pkg::*;
#(
  parameter int STATION_ID = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dispValid,
  input  logic [OP_W-1:0]        dispOp,
  input  logic [SRCS-1:0]        dispRdy,
  input  logic [SRCS*DATA_W-1:0] dispData,
  input  logic [SRCS*TAG_W-1:0]  dispTag,
  output logic                   full,
  input  logic                   cdbValid,
  input  logic [TAG_W-1:0]       cdbTag,
  input  logic [DATA_W-1:0]      cdbData,
  output logic                   issueValid,
  input  logic                   issueReady,
  output logic [OP_W-1:0]        issueOp,
  output logic [SRCS*DATA_W-1:0] issueData,
  output logic [TAG_W-1:0]       issueTag
);
  rsStrobe_t          strb;
  logic [ENTRIES-1:0] entRdy;

  rs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dispValid  (dispValid),
    .issueReady (issueReady),
    .entRdy     (entRdy),
    .full       (full),
    .issueValid (issueValid),
    .strb       (strb)
  );

  rs_data #(.STATION_ID(STATION_ID)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dispOp    (dispOp),
    .dispRdy   (dispRdy),
    .dispData  (dispData),
    .dispTag   (dispTag),
    .cdbValid  (cdbValid),
    .cdbTag    (cdbTag),
    .cdbData   (cdbData),
    .entRdy    (entRdy),
    .issueOp   (issueOp),
    .issueData (issueData),
    .issueTag  (issueTag)
  );
endmodule

// File: rtl/rs_checker.sv
`timescale 1ns/1ps
module rs_checker
  import rs_pkg::*;
#(
  parameter int STATION_ID = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic             full,
  input logic             issueValid,
  input logic             issueReady,
  input logic [TAG_W-1:0] issueTag
);
  logic [IDX_W:0] cnt;
  logic acc, done;

  assign acc  = dispValid && !full;
  assign done = issueValid && issueReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + (IDX_W+1)'(acc) - (IDX_W+1)'(done);
  end

  // R2
  full_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    full == (cnt == (IDX_W+1)'(ENTRIES)));

  // R6
  no_issue_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> cnt != '0);

  // R9
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueReady |=> issueValid);

  // R10
  station_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> issueTag[TAG_W-1 -: SID_W] == SID_W'(STATION_ID));

  // R2
  full_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && !done |=> full);
endmodule

bind rs_station rs_checker #(.STATION_ID(STATION_ID)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dispValid  (dispValid),
  .full       (full),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .issueTag   (issueTag)
);

// File: tb/sim_rs_station.sv
`timescale 1ns/1ps
module sim_rs_station;
  logic        clk = 1'b0;
  logic        rstN;
  logic        dispValid;
  logic [3:0]  dispOp;
  logic [1:0]  dispRdy;
  logic [63:0] dispData;
  logic [7:0]  dispTag;
  logic        full;
  logic        cdbValid;
  logic [3:0]  cdbTag;
  logic [31:0] cdbData;
  logic        issueValid;
  logic        issueReady;
  logic [3:0]  issueOp;
  logic [63:0] issueData;
  logic [3:0]  issueTag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rs_station #(.STATION_ID(1)) u0 (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispOp(dispOp),
    .dispRdy(dispRdy), .dispData(dispData), .dispTag(dispTag), .full(full),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .issueValid(issueValid), .issueReady(issueReady), .issueOp(issueOp),
    .issueData(issueData), .issueTag(issueTag)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic disp(input logic [3:0] op, input logic r0, input logic [31:0] a,
                      input logic [3:0] t0, input logic r1, input logic [31:0] b,
                      input logic [3:0] t1);
    dispValid = 1'b1; dispOp = op; dispRdy = {r1, r0};
    dispData = {b, a}; dispTag = {t1, t0};
    step();
    dispValid = 1'b0; dispRdy = '0;
  endtask

  task automatic bcast(input logic [3:0] tag, input logic [31:0] data);
    cdbValid = 1'b1; cdbTag = tag; cdbData = data;
    step();
    cdbValid = 1'b0;
  endtask

  task automatic pop(input string req, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [3:0] tag);
    chk({req, " valid"}, 64'(issueValid), 64'd1);
    chk({req, " op"}, 64'(issueOp), 64'(op));
    chk({req, " data R12"}, issueData, {b, a});
    chk({req, " tag"}, 64'(issueTag), 64'(tag));
    issueReady = 1'b1;
    step();
    issueReady = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; dispValid = 0; dispOp = 0; dispRdy = 0; dispData = 0; dispTag = 0;
    cdbValid = 0; cdbTag = 0; cdbData = 0; issueReady = 0;
    step(); step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 valid", 64'(issueValid), 64'd0);
    chk("R1 full", 64'(full), 64'd0);

    // R3 R10: both sources ready, slot 0, tag 4
    disp(4'd1, 1, 32'd5, 4'd0, 1, 32'd7, 4'd0);
    pop("R3", 4'd1, 32'd5, 32'd7, 4'd4);

    // R7 R4: older waits on tag 9, younger ready goes first
    disp(4'd2, 0, 32'd0, 4'd9, 1, 32'd3, 4'd0);
    disp(4'd3, 1, 32'd20, 4'd0, 1, 32'd21, 4'd0);
    pop("R7", 4'd3, 32'd20, 32'd21, 4'd5);
    bcast(4'd8, 32'hDEAD);
    chk("R4 other tag ignored", 64'(issueValid), 64'd0);
    bcast(4'd9, 32'd11);
    pop("R4", 4'd2, 32'd11, 32'd3, 4'd4);

    // R5: broadcast coincident with dispatch
    cdbValid = 1'b1; cdbTag = 4'd6; cdbData = 32'd42;
    disp(4'd5, 1, 32'd1, 4'd0, 0, 32'd0, 4'd6);
    cdbValid = 1'b0;
    pop("R5", 4'd5, 32'd1, 32'd42, 4'd4);

    // R2 R8 R9 R10: fill, refuse, drain in age order
    for (int i = 0; i < 4; i++)
      disp(4'(10 + i), 1, 32'(100 + i), 4'd0, 1, 32'(200 + i), 4'd0);
    chk("R2 full", 64'(full), 64'd1);
    disp(4'd14, 1, 32'd999, 4'd0, 1, 32'd999, 4'd0);
    chk("R2 still full", 64'(full), 64'd1);
    step();
    chk("R9 hold valid", 64'(issueValid), 64'd1);
    chk("R9 hold op", 64'(issueOp), 64'd10);
    pop("R8", 4'd10, 32'd100, 32'd200, 4'd4);
    chk("R9 freed", 64'(full), 64'd0);
    for (int i = 1; i < 4; i++)
      pop("R10", 4'(10 + i), 32'(100 + i), 32'(200 + i), 4'(4 + i));
    chk("R2 refused dropped", 64'(issueValid), 64'd0);

    // R8: older slot has higher index
    disp(4'd4, 1, 32'd1, 4'd0, 1, 32'd2, 4'd0);
    disp(4'd6, 0, 32'd0, 4'd7, 1, 32'd9, 4'd0);
    pop("R8 first", 4'd4, 32'd1, 32'd2, 4'd4);
    disp(4'd7, 0, 32'd0, 4'd7, 1, 32'd8, 4'd0);
    chk("R6 none ready", 64'(issueValid), 64'd0);
    bcast(4'd7, 32'd100);
    pop("R8 oldest", 4'd6, 32'd100, 32'd9, 4'd5);
    pop("R8 next", 4'd7, 32'd100, 32'd8, 4'd4);

    // R11: dependent chain through own tags
    disp(4'd8, 0, 32'd0, 4'd12, 1, 32'd2, 4'd0);
    disp(4'd9, 0, 32'd0, 4'd4, 1, 32'd3, 4'd0);
    disp(4'd10, 0, 32'd0, 4'd5, 1, 32'd4, 4'd0);
    chk("R11 waiting", 64'(issueValid), 64'd0);
    bcast(4'd12, 32'd10);
    pop("R11 x", 4'd8, 32'd10, 32'd2, 4'd4);
    bcast(4'd4, 32'd12);
    pop("R11 y", 4'd9, 32'd12, 32'd3, 4'd5);
    bcast(4'd5, 32'd15);
    pop("R11 z", 4'd10, 32'd15, 32'd4, 4'd6);
    chk("R11 empty", 64'(issueValid), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule